// File: doc/BRIEF.md
# PRBS7 Link Self-Test Checker

This block is the receive-side checker for an at-speed self-test of a serial link. Each received 24-bit payload word arrives with a valid strobe. While the test enable input is high, the block compares every valid word against a locally generated PRBS7 sequence. It reports each errored word as a short low pulse on a single pass/fail pin. The width of the enable pulse sets the length of the test; nothing else defines the window. When enable drops, checking stops and the same pin holds the verdict: high means the run was clean, low means at least one word was wrong.

At the start of a run the checker does not need to know the transmitter's phase. It takes its 7-bit generator state from the first valid word it sees and checks every word after that. While the test runs, the normal parallel data and control outputs are forced to zero so that test traffic never reaches downstream logic. For checking in simulation, a registered one-cycle error strobe and a saturating errored-word counter are also brought out.

Top module: `lbist_rx_checker`

## Requirements
- R1: The expected sequence follows the polynomial x^7 + x^6 + 1, so that bit b(n) = b(n-7) XOR b(n-6). Each word carries 24 consecutive sequence bits, with bit 23 the earliest. A word that matches the prediction causes no error indication.
- R2: The first valid word after enable rises is not checked. It loads the 7-bit state from its bits [6:0], where bit 0 is the most recent sequence bit. If those seven bits are all zero, the state is set to 7'b0000001 instead.
- R3: A checked word that differs from the prediction in any number of bits from 1 to 24 raises err_stb_o for exactly the one cycle after the clock edge that captured it, and increments err_cnt_o by one.
- R4: While a run is active, pass_o is high, except during the low half of a cycle in which err_stb_o is high; there it is low.
- R5: After enable goes low, received words have no effect. pass_o holds 1 if the run saw no errored word and 0 otherwise, and err_cnt_o stays constant.
- R6: A rising edge of enable clears the error history and the counter, so pass_o reads high and err_cnt_o reads zero for the new run.
- R7: err_cnt_o saturates at 16'hFFFF and does not wrap.
- R8: One cycle after an edge at which enable is high, out_valid, out_data and out_ctrl are zero. Otherwise they show rx_valid, rx_data and rx_ctrl with one cycle of latency.
- R9: Words presented with rx_valid low are neither checked nor used to advance the sequence.
- R10: While reset is high and after it, before any run, pass_o is 1, err_stb_o is 0, err_cnt_o is 0 and the data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en | input | 1 | Self-test enable; its high time is the test window |
| rx_valid | input | 1 | Received word strobe |
| rx_data | input | 24 | Received payload word, bit 23 earliest |
| rx_ctrl | input | 3 | Received control bits |
| out_valid | output | 1 | Forwarded word strobe, blanked during test |
| out_data | output | 24 | Forwarded payload, blanked during test |
| out_ctrl | output | 3 | Forwarded control bits, blanked during test |
| pass_o | output | 1 | Per-word error pulses during a run, held verdict after it |
| err_stb_o | output | 1 | Registered one-cycle errored-word strobe |
| err_cnt_o | output | 16 | Saturating errored-word count for the current run |

## Verification
Two situations are hard to reach from the ports. The first is counter saturation, which needs 65,535 errored words in a single run. The bench gets there by sending inverted predictions for about 65.5k consecutive cycles and then checking that the count sits at its ceiling while err_stb_o keeps pulsing. The second is the half-cycle pulse on pass_o, which is only visible in the low phase of the clock. Every errored-word check therefore samples pass_o twice: once in the high phase and once in the low phase. Locking is swept across all 127 nonzero starting states. The error weights 1 to 24 are each injected once, with a clean word after each one.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int PRBS_W = 7;
  typedef logic [PRBS_W-1:0] prbs_t;
  localparam prbs_t SEED_FIX = 7'h01;
endpackage

// File: rtl/prbs7_predict.sv
module prbs7_predict
  import lbist_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  prbs_t             state_i,
  output logic [WORD_W-1:0] word_o,
  output prbs_t             next_o
);
  prbs_t chain [0:WORD_W];
  assign chain[0] = state_i;

  for (genvar j = 0; j < WORD_W; j++) begin : g_step
    logic bit_j;
    assign bit_j              = chain[j][6] ^ chain[j][5];
    assign word_o[WORD_W-1-j] = bit_j;
    assign chain[j+1]         = {chain[j][5:0], bit_j};
  end

  assign next_o = chain[WORD_W];
endmodule

// File: rtl/bist_tracker.sv
module bist_tracker
  import lbist_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bist_en,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  output logic              run_o,
  output logic              err_stb_o,
  output logic              sticky_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              run_q, locked_q, err_q, sticky_q;
  logic [CNT_W-1:0]  cnt_q;
  prbs_t             state_q, seed, pred_next;
  logic [WORD_W-1:0] pred_word;
  logic              rise, mismatch;

  prbs7_predict #(.WORD_W(WORD_W)) u_pred (
    .state_i (state_q),
    .word_o  (pred_word),
    .next_o  (pred_next)
  );

  assign rise     = bist_en & ~run_q;
  assign mismatch = |(rx_data ^ pred_word);
  assign seed     = (rx_data[PRBS_W-1:0] == '0) ? SEED_FIX : rx_data[PRBS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
      cnt_q    <= '0;
      state_q  <= SEED_FIX;
    end else begin
      run_q <= bist_en;
      err_q <= 1'b0;
      if (rise) begin
        sticky_q <= 1'b0;
        cnt_q    <= '0;
        locked_q <= rx_valid;
        if (rx_valid) state_q <= seed;
      end else if (bist_en && rx_valid) begin
        if (!locked_q) begin
          state_q  <= seed;
          locked_q <= 1'b1;
        end else begin
          state_q <= pred_next;
          if (mismatch) begin
            err_q    <= 1'b1;
            sticky_q <= 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign run_o     = run_q;
  assign err_stb_o = err_q;
  assign sticky_o  = sticky_q;
  assign cnt_o     = cnt_q;

  // R3
  err_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> run_q);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || ($past(cnt_q) == CNT_MAX));
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && run_q) |=> cnt_q == CNT_MAX);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bist_en |=> ($stable(sticky_q) && $stable(cnt_q) && !err_q));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt_q == '0 && !sticky_q));
endmodule

// File: rtl/out_blank.sv
module out_blank #(
  parameter int WORD_W = 24,
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blank,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl
);
  always_ff @(posedge clk) begin
    if (rst || blank) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_data;
      out_ctrl  <= in_ctrl;
    end
  end

  // R8
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    blank |=> (!out_valid && out_data == '0 && out_ctrl == '0));
  // R8
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    !blank |=> (out_data == $past(in_data) && out_valid == $past(in_valid)));
endmodule

// File: rtl/lbist_rx_checker.sv
module lbist_rx_checker #(
  parameter int WORD_W = 24,
  parameter int CTRL_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bist_en,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  input  logic [CTRL_W-1:0] rx_ctrl,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              pass_o,
  output logic              err_stb_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic run, sticky;

  bist_tracker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .bist_en   (bist_en),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .run_o     (run),
    .err_stb_o (err_stb_o),
    .sticky_o  (sticky),
    .cnt_o     (err_cnt_o)
  );

  out_blank #(.WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .blank     (bist_en),
    .in_valid  (rx_valid),
    .in_data   (rx_data),
    .in_ctrl   (rx_ctrl),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl)
  );

  // Low half-period pulse per errored word while running; held verdict otherwise.
  assign pass_o = run ? ~(err_stb_o & ~clk) : ~sticky;

  // R10
  reset_pass_chk: assert property (@(posedge clk)
    $past(rst) |-> (err_cnt_o == '0 && !err_stb_o && !out_valid));
endmodule

// File: tb/tb_lbist_rx_checker.sv
module tb_lbist_rx_checker;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, bist_en, rx_valid;
  logic [23:0] rx_data;
  logic [2:0]  rx_ctrl;
  logic        out_valid, pass_o, err_stb_o;
  logic [23:0] out_data;
  logic [2:0]  out_ctrl;
  logic [15:0] err_cnt_o;

  int errors = 0;
  int checks = 0;
  logic [6:0] gst;

  lbist_rx_checker dut (
    .clk(clk), .rst(rst), .bist_en(bist_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl), .out_valid(out_valid),
    .out_data(out_data), .out_ctrl(out_ctrl), .pass_o(pass_o),
    .err_stb_o(err_stb_o), .err_cnt_o(err_cnt_o)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Stimulus model: 24 bits of b(n)=b(n-7)^b(n-6), earliest bit in bit 23.
  function automatic logic [23:0] gen_word(inout logic [6:0] s);
    logic [23:0] w;
    for (int i = 23; i >= 0; i--) begin
      w[i] = s[6] ^ s[5];
      s = {s[5:0], w[i]};
    end
    return w;
  endfunction

  // Drive at a low-phase time, wait for the edge, return 2 time units into the high phase.
  task automatic step(input logic en, input logic v, input logic [23:0] d);
    bist_en = en; rx_valid = v; rx_data = d; rx_ctrl = d[2:0];
    @(posedge clk); #2;
  endtask

  task automatic low_phase(); #5; endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] w;
    rst = 1'b1; bist_en = 0; rx_valid = 0; rx_data = '0; rx_ctrl = '0;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check("R10 pass", pass_o, 1);
    check("R10 cnt", err_cnt_o, 0);
    check("R10 err", err_stb_o, 0);
    check("R10 out_valid", out_valid, 0);
    #5 rst = 1'b0;

    // R8 pass-through outside a run
    step(0, 1, 24'hA5A5A5);
    check("R8 data", out_data, 24'hA5A5A5);
    check("R8 valid", out_valid, 1);
    check("R8 ctrl", out_ctrl, 3'h5);
    check("R10 pass before run", pass_o, 1);
    low_phase();

    // R1 R2 R9 sweep over every nonzero start state
    for (int s = 1; s < 128; s++) begin
      gst = 7'(s);
      step(1, 1, gen_word(gst));
      check("R2 seed word unchecked", err_stb_o, 0);
      check("R6 cnt cleared", err_cnt_o, 0);
      for (int k = 0; k < 3; k++) begin
        logic [6:0] peek;
        peek = gst;
        step(1, 0, ~gen_word(peek));
        check("R9 invalid ignored", err_stb_o, 0);
        check("R8 blanked", {out_valid, out_data}, 0);
        low_phase();
        step(1, 1, gen_word(gst));
        check("R1 clean word", err_stb_o, 0);
        low_phase();
        check("R4 pass high clean", pass_o, 1);
      end
      step(0, 0, '0);
      check("R5 clean verdict", pass_o, 1);
      check("R5 cnt zero", err_cnt_o, 0);
      low_phase();
    end

    // R3 R4 error weights 1..24
    gst = 7'h2A;
    step(1, 1, gen_word(gst));
    low_phase();
    for (int k = 1; k <= 24; k++) begin
      logic [23:0] mask;
      mask = (k == 24) ? 24'hFFFFFF : ((24'h1 << k) - 24'h1);
      step(1, 1, gen_word(gst) ^ mask);
      check("R3 err strobe", err_stb_o, 1);
      check("R3 count", err_cnt_o, 32'(k));
      check("R4 pass high phase", pass_o, 1);
      low_phase();
      check("R4 pass low pulse", pass_o, 0);
      step(1, 1, gen_word(gst));
      check("R3 clean after err", err_stb_o, 0);
      low_phase();
      check("R4 pass high after", pass_o, 1);
    end
    step(0, 1, 24'h0);
    check("R5 fail verdict", pass_o, 0);
    low_phase();
    check("R5 fail verdict low phase", pass_o, 0);
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 24'h5A5A5A ^ 24'(k));
      check("R5 ignored err", err_stb_o, 0);
      check("R5 cnt held", err_cnt_o, 24);
      check("R5 pass held", pass_o, 0);
      low_phase();
    end

    // R6 new run clears; R2 all-ones seed (not checked) and all-zero seed
    step(1, 1, 24'hFFFFFF);
    check("R6 pass reset", pass_o, 1);
    check("R6 cnt reset", err_cnt_o, 0);
    check("R2 garbage seed unchecked", err_stb_o, 0);
    low_phase();
    gst = 7'h7F;
    step(1, 1, gen_word(gst));
    check("R2 seed from low bits", err_stb_o, 0);
    low_phase();
    step(0, 0, '0); low_phase();
    step(1, 1, 24'h123480);
    low_phase();
    gst = 7'h01;
    for (int k = 0; k < 4; k++) begin
      step(1, 1, gen_word(gst));
      check("R2 zero seed forced to 1", err_stb_o, 0);
      low_phase();
    end
    step(0, 0, '0);
    check("R2 zero seed verdict", pass_o, 1);
    low_phase();

    // R7 saturation
    gst = 7'h11;
    step(1, 1, gen_word(gst));
    low_phase();
    for (int k = 0; k < 65540; k++) begin
      w = gen_word(gst);
      bist_en = 1; rx_valid = 1; rx_data = ~w;
      @(posedge clk); #2;
    end
    check("R7 saturated", err_cnt_o, 16'hFFFF);
    check("R7 strobe at ceiling", err_stb_o, 1);
    #5;
    step(0, 0, '0);
    check("R7 cnt held", err_cnt_o, 16'hFFFF);
    check("R5 verdict after sat", pass_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule